// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and presents a single interrupt to the processor. A request is forwarded only if its line is not masked and it outranks every level already in service. Priority is fixed, with line 0 highest and line 7 lowest. A one-cycle acknowledge pulse from the processor moves the winning level from the request register into the in-service register. On the cycle after the pulse, the block returns an 8-bit vector made of a programmed base and the level number.

Software reaches the block through a two-address register port. Address 0 is the command port and address 1 is the data port. Writing to the command port with bit 4 set starts an initialization sequence. The data-port writes that follow supply the vector base, the cascade configuration and the mode word. Once initialization is complete, data-port writes load the mask, and command-port writes issue end-of-interrupt commands or choose which register a command-port read returns.

Several controllers can be cascaded. The `master_sel` pin picks the role. A master names on `cas_out` the level that has a slave attached and leaves the vector bus to that slave. A slave answers an acknowledge only when `cas_in` matches its programmed identity. A request that disappears before it is acknowledged produces a spurious level-7 vector, and no in-service bit is set.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is 0xFF, the request and in-service registers are 0, command-port reads return the request register, and `int_out` and `vec_drive` are low.
- R2: A command-port write with bit 4 set clears the request and in-service registers, leaves the mask unchanged, turns auto end-of-interrupt off and selects the request register for reads. The data writes that follow are: the base word; then the cascade word, only if bit 1 of the start word is 0; then the mode word, only if bit 0 of the start word is 1. After these, data writes load the mask again.
- R3: The returned vector is bits 7:3 of the base word followed by the 3-bit level number.
- R4: Outside initialization, a data-port write loads the mask, where bit n = 1 blocks line n. A data-port read returns the mask.
- R5: Each line passes through a two-stage synchronizer. A rising edge of the synchronized level sets its request bit. The bit clears when the synchronized level is low or when that level is acknowledged.
- R6: `int_out` is high exactly when the lowest-numbered unmasked request bit has a lower number than every set in-service bit. It is computed from registered state.
- R7: An acknowledge with `int_out` high clears that request bit and, in normal mode, sets its in-service bit. The vector is valid and `vec_drive` pulses high in the following cycle.
- R8: Mode word bit 1 = 1 selects auto end-of-interrupt: an acknowledge then sets no in-service bit. Mode word 0x01 selects normal end-of-interrupt.
- R9: A command write of 0x60+n clears in-service bit n only. A command write of 0x20 clears the lowest-numbered set in-service bit.
- R10: A command write of 0x0A selects the request register for command-port reads, and 0x0B selects the in-service register. The choice holds until it is changed again.
- R11: An acknowledge while `int_out` is low returns the vector base|7, drives it, and leaves the in-service register unchanged.
- R12: On a master in cascade mode, the cascade word is a bitmap of lines that have a slave attached. Acknowledging such a line sets its in-service bit, keeps `vec_drive` low and puts the level on `cas_out`.
- R13: On a slave in cascade mode, bits 2:0 of the cascade word are its identity. An acknowledge with `cas_in` different from that identity changes nothing and keeps `vec_drive` low. A matching `cas_in` is handled as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected port |
| irq_in | input | 8 | Asynchronous request lines, line 0 highest |
| int_out | output | 1 | Interrupt to the processor |
| inta | input | 1 | One-cycle acknowledge pulse |
| vector | output | 8 | Vector returned by the last acknowledge |
| vec_drive | output | 1 | High for one cycle when this controller owns the vector |
| master_sel | input | 1 | 1 = master, 0 = slave |
| cas_in | input | 3 | Cascade identity presented to a slave |
| cas_out | output | 3 | Level forwarded to a slave by a master |

## Verification
The assertions check on every cycle that the interrupt output is never raised without an unmasked pending request, and that a ready-state data write lands in the mask. They also check that an acknowledge in normal mode grows the in-service register by exactly one bit, and that auto end-of-interrupt never grows it. The remaining per-cycle checks cover the spurious level-7 response and the silence of a slave that is not addressed. Only the bench scenarios can show the rest: ordering among nested levels, specific versus non-specific end-of-interrupt, the persistence of the readback selection, the skipped words of a short initialization, and the decision between vector ownership and cascade forwarding.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LINES = 8;
    localparam int IDXW  = $clog2(LINES);
    localparam int BASEW = LINES - IDXW;

    typedef enum logic [1:0] {
        ST_READY,
        ST_BASE,
        ST_CASC,
        ST_MODE
    } init_st_e;

    typedef struct packed {
        init_st_e              st;
        logic [LINES-1:0]      mask;
        logic [LINES-1:0]      irr;
        logic [LINES-1:0]      isr;
        logic [BASEW-1:0]      base;
        logic [LINES-1:0]      casc_word;
        logic                  casc;
        logic                  need_mode;
        logic                  aeoi;
        logic                  rd_isr;
        logic [LINES-1:0]      vec;
        logic                  vdrv;
        logic [IDXW-1:0]       cas;
    } pic_state_t;
endpackage

// File: rtl/pic_in_sync.sv
module pic_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    for (genvar b = 0; b < W; b++) begin : g_line
        logic [STAGES:0] chain_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-1:0], din[b]};
            end
        end

        assign lvl[b]  = chain_q[STAGES-1];
        assign rise[b] = chain_q[STAGES-1] & ~chain_q[STAGES];
    end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [7:0]       irq_in,
    output logic             int_out,
    input  logic             inta,
    output logic [7:0]       vector,
    output logic             vec_drive,
    input  logic             master_sel,
    input  logic [2:0]       cas_in,
    output logic [2:0]       cas_out
);
    pic_state_t s_q, s_d;

    logic [LINES-1:0] lvl, rise;
    logic             pend_any, isr_any;
    logic [IDXW-1:0]  pend_idx, isr_idx;

    // Plain views of state for the read port and the bound checker
    logic [LINES-1:0] mask_q, irr_q, isr_q, casc_word_q;
    logic             aeoi_q, ready_q, casc_q;

    assign mask_q      = s_q.mask;
    assign irr_q       = s_q.irr;
    assign isr_q       = s_q.isr;
    assign casc_word_q = s_q.casc_word;
    assign aeoi_q      = s_q.aeoi;
    assign casc_q      = s_q.casc;
    assign ready_q     = (s_q.st == ST_READY);

    pic_in_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_in),
        .lvl  (lvl),
        .rise (rise)
    );

    pic_prio #(.W(LINES), .IW(IDXW)) u_pend (
        .req(irr_q & ~mask_q),
        .any(pend_any),
        .idx(pend_idx)
    );

    pic_prio #(.W(LINES), .IW(IDXW)) u_serv (
        .req(isr_q),
        .any(isr_any),
        .idx(isr_idx)
    );

    logic cmd_w, dat_w, responds, to_slave;

    always_comb begin
        int_out  = pend_any && (!isr_any || (pend_idx < isr_idx));
        cmd_w    = wr_en && !addr;
        dat_w    = wr_en && addr;
        responds = master_sel || !casc_q || (cas_in == casc_word_q[IDXW-1:0]);
        to_slave = master_sel && casc_q && casc_word_q[pend_idx];
        rdata    = addr ? mask_q : (s_q.rd_isr ? isr_q : irr_q);
    end

    always_comb begin
        s_d      = s_q;
        s_d.vdrv = 1'b0;

        if (cmd_w && wdata[4]) begin
            s_d.st        = ST_BASE;
            s_d.need_mode = wdata[0];
            s_d.casc      = !wdata[1];
            s_d.irr       = '0;
            s_d.isr       = '0;
            s_d.aeoi      = 1'b0;
            s_d.rd_isr    = 1'b0;
        end else begin
            s_d.irr = (s_q.irr | rise) & lvl;

            if (cmd_w && !wdata[3]) begin
                if (wdata[7:5] == 3'b011) begin
                    s_d.isr[wdata[IDXW-1:0]] = 1'b0;
                end else if (wdata[7:5] == 3'b001 && isr_any) begin
                    s_d.isr[isr_idx] = 1'b0;
                end
            end

            if (cmd_w && wdata[3] && wdata[1]) begin
                s_d.rd_isr = wdata[0];
            end

            if (dat_w) begin
                unique case (s_q.st)
                    ST_READY: s_d.mask = wdata;
                    ST_BASE: begin
                        s_d.base = wdata[7:IDXW];
                        if (s_q.casc)           s_d.st = ST_CASC;
                        else if (s_q.need_mode) s_d.st = ST_MODE;
                        else                    s_d.st = ST_READY;
                    end
                    ST_CASC: begin
                        s_d.casc_word = wdata;
                        s_d.st        = s_q.need_mode ? ST_MODE : ST_READY;
                    end
                    ST_MODE: begin
                        s_d.aeoi = wdata[1];
                        s_d.st   = ST_READY;
                    end
                    default: s_d.st = ST_READY;
                endcase
            end

            if (inta && responds) begin
                if (int_out) begin
                    s_d.irr[pend_idx] = 1'b0;
                    if (!s_q.aeoi) s_d.isr[pend_idx] = 1'b1;
                    s_d.vec = {s_q.base, pend_idx};
                    if (to_slave) begin
                        s_d.cas  = pend_idx;
                        s_d.vdrv = 1'b0;
                    end else begin
                        s_d.vdrv = 1'b1;
                    end
                end else begin
                    s_d.vec  = {s_q.base, {IDXW{1'b1}}};
                    s_d.vdrv = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.st        <= ST_READY;
            s_q.mask      <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign vector    = s_q.vec;
    assign vec_drive = s_q.vdrv;
    assign cas_out   = s_q.cas;
endmodule

// File: rtl/pic_chk.sv
module pic_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic       inta,
    input logic       int_out,
    input logic [7:0] vector,
    input logic       vec_drive,
    input logic       master_sel,
    input logic [2:0] cas_in,
    input logic [7:0] mask_q,
    input logic [7:0] irr_q,
    input logic [7:0] isr_q,
    input logic [7:0] casc_word_q,
    input logic       aeoi_q,
    input logic       casc_q,
    input logic       ready_q
);
    // R6
    int_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr_q & ~mask_q) != 8'h00));

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && ready_q) |=> (mask_q == $past(wdata)));

    // R7
    ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && master_sel && int_out && !aeoi_q && !wr_en)
        |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

    // R8
    aeoi_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && aeoi_q && !wr_en)
        |=> ($countones(isr_q) <= $countones($past(isr_q))));

    // R11
    spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && master_sel && !int_out && !wr_en)
        |=> (vector[2:0] == 3'd7 && vec_drive && isr_q == $past(isr_q)));

    // R13
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !master_sel && casc_q && cas_in != casc_word_q[2:0])
        |=> !vec_drive);
endmodule

bind prio_irq_ctrl pic_chk u_pic_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .inta       (inta),
    .int_out    (int_out),
    .vector     (vector),
    .vec_drive  (vec_drive),
    .master_sel (master_sel),
    .cas_in     (cas_in),
    .mask_q     (mask_q),
    .irr_q      (irr_q),
    .isr_q      (isr_q),
    .casc_word_q(casc_word_q),
    .aeoi_q     (aeoi_q),
    .casc_q     (casc_q),
    .ready_q    (ready_q)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_out;
    logic       inta = 1'b0;
    logic [7:0] vector;
    logic       vec_drive;
    logic       master_sel = 1'b1;
    logic [2:0] cas_in = 3'd0;
    logic [2:0] cas_out;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .inta(inta),
        .vector(vector), .vec_drive(vec_drive), .master_sel(master_sel),
        .cas_in(cas_in), .cas_out(cas_out)
    );

    // mask, irq pattern, expected int_out, expected vector (base 0x20)
    localparam logic [31:0] TAB [0:6] = '{
        32'h00_01_01_20,
        32'h00_88_01_23,
        32'h08_88_01_27,
        32'hFF_FF_00_00,
        32'h00_60_01_25,
        32'h01_03_01_21,
        32'h0F_0F_00_00
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic ack();
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        #1;
    endtask

    task automatic init(input logic [7:0] base, input logic [7:0] cw, input logic [7:0] mode);
        wr(1'b0, 8'h11);
        wr(1'b1, base);
        wr(1'b1, cw);
        wr(1'b1, mode);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 int_out", {7'd0, int_out}, 8'h00);
        chk("R1 vec_drive", {7'd0, vec_drive}, 8'h00);
        rd(1'b1, v); chk("R1 mask", v, 8'hFF);
        rd(1'b0, v); chk("R1 irr", v, 8'h00);

        wr(1'b1, 8'hFF);
        init(8'h20, 8'h04, 8'h01);

        // R3 R4 R6 R7 table walk
        for (int k = 0; k < 7; k++) begin
            wr(1'b1, TAB[k][31:24]);
            irq_in = TAB[k][23:16];
            tick(4);
            chk($sformatf("R6 int_out entry %0d", k), {7'd0, int_out}, TAB[k][15:8]);
            if (TAB[k][8]) begin
                ack();
                chk($sformatf("R3 vector entry %0d", k), vector, TAB[k][7:0]);
                chk($sformatf("R7 vec_drive entry %0d", k), {7'd0, vec_drive}, 8'h01);
                tick(1);
                wr(1'b0, 8'h20);
            end
            irq_in = 8'h00;
            tick(4);
        end
        wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R4 mask readback", v, 8'h00);

        // Nested priority, readback select, EOI forms
        irq_in = 8'h20; tick(4);
        ack(); chk("R7 vector lvl5", vector, 8'h25);
        tick(1);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R10 isr after lvl5", v, 8'h20);
        irq_in = 8'h60; tick(4);
        chk("R6 lower level blocked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); chk("R5 irr shows lvl6", v, 8'h40);
        tick(2);
        rd(1'b0, v); chk("R10 select persists", v, 8'h40);
        irq_in = 8'h62; tick(4);
        chk("R6 higher level nests", {7'd0, int_out}, 8'h01);
        ack(); chk("R7 vector lvl1", vector, 8'h21);
        tick(1);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R7 isr nested", v, 8'h22);
        wr(1'b0, 8'h61);
        rd(1'b0, v); chk("R9 specific eoi", v, 8'h20);
        chk("R6 still blocked by lvl5", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R9 nonspecific eoi", v, 8'h00);
        chk("R6 lvl6 now forwarded", {7'd0, int_out}, 8'h01);
        ack(); chk("R7 vector lvl6", vector, 8'h26);
        tick(1);
        wr(1'b0, 8'h66);
        irq_in = 8'h00; tick(4);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); chk("R5 irr clears on low", v, 8'h00);

        // Spurious request
        irq_in = 8'h10; tick(4);
        chk("R11 raised", {7'd0, int_out}, 8'h01);
        irq_in = 8'h00; tick(4);
        chk("R11 withdrawn", {7'd0, int_out}, 8'h00);
        ack();
        chk("R11 spurious vector", vector, 8'h27);
        chk("R11 spurious drive", {7'd0, vec_drive}, 8'h01);
        tick(1);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R11 isr untouched", v, 8'h00);

        // Master forwarding to slave on line 2
        irq_in = 8'h04; tick(4);
        ack();
        chk("R12 no vector drive", {7'd0, vec_drive}, 8'h00);
        chk("R12 cas_out", {5'd0, cas_out}, 8'h02);
        tick(1);
        rd(1'b0, v); chk("R12 isr set", v, 8'h04);
        wr(1'b0, 8'h62);
        irq_in = 8'h00; tick(4);

        // Auto end-of-interrupt
        init(8'h20, 8'h04, 8'h03);
        rd(1'b1, v); chk("R2 mask kept", v, 8'h00);
        irq_in = 8'h08; tick(4);
        rd(1'b0, v); chk("R2 read select back to irr", v, 8'h08);
        ack(); chk("R8 vector", vector, 8'h23);
        tick(1);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R8 isr stays clear", v, 8'h00);
        chk("R8 int_out low", {7'd0, int_out}, 8'h00);
        irq_in = 8'h00; tick(4);

        // Short init: single, no mode word
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h5A);
        rd(1'b1, v); chk("R2 short init mask", v, 8'h5A);
        wr(1'b1, 8'h00);
        irq_in = 8'h01; tick(4);
        ack(); chk("R3 new base", vector, 8'h40);
        tick(1);
        wr(1'b0, 8'h20);
        irq_in = 8'h00; tick(4);

        // Slave role
        master_sel = 1'b0;
        init(8'h30, 8'h02, 8'h01);
        wr(1'b1, 8'h00);
        irq_in = 8'h10; tick(4);
        cas_in = 3'd5;
        ack();
        chk("R13 other id silent", {7'd0, vec_drive}, 8'h00);
        tick(1);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R13 isr unchanged", v, 8'h00);
        chk("R13 still requesting", {7'd0, int_out}, 8'h01);
        cas_in = 3'd2;
        ack();
        chk("R13 own id drives", {7'd0, vec_drive}, 8'h01);
        chk("R13 slave vector", vector, 8'h34);
        tick(1);
        rd(1'b0, v); chk("R13 isr set", v, 8'h10);
        wr(1'b0, 8'h20);
        irq_in = 8'h00; tick(4);

        summary();
    end
endmodule